// File: doc/BRIEF.md
# Register-List Block Load Sequencer

This block carries out a multi-register load from memory with post-increment addressing, the kind of transfer a move-multiple instruction performs when it fills several registers from consecutive longwords. A start pulse hands it a 16-bit register-select mask, a base address and the index of the address register that holds the base. The block then walks the mask, issues one 32-bit read per selected register over a simple request/acknowledge bus, and writes each returned word into a register-file write port. After the last register it writes the advanced address back into the base register.

A mode input picks between two generations of core. The older behaviour ends the sequence with one extra 16-bit read at the final address, and a bus error on that read is reported. The newer behaviour ends after the base write-back. A resume input lets the same load be restarted after a bus fault. The caller passes the count of transfers that had already finished, and optionally a word that was already fetched. The block then skips what was completed, still advancing the address past those registers, and continues from there. A cycle-cost output totals a fixed amount per register loaded.

Top module: `reglist_loader`

## Requirements
- R1: Mask bit n with n in 0..7 selects data register n, written with `rfSel`=0 and `rfIdx`=n. Mask bit n with n in 8..15 selects address register n-8, written with `rfSel`=1 and `rfIdx`=n-8.
- R2: Every selected data register is written before any selected address register. Within each group, registers are written from the lowest index to the highest.
- R3: Each register loaded from memory takes exactly one longword read (`busSize`=0). The first read goes to the base address and each later read goes 4 higher. The request is held with a stable address until it is acknowledged or errors.
- R4: After the last register, the block writes the base register once (`rfSel`=1, `rfIdx`=base index) with base + 4 × (number of set mask bits).
- R5: When `legacyMode`=1, exactly one word read (`busSize`=1) is made at the final address after the base write-back. When `legacyMode`=0, no read follows the base write-back.
- R6: A bus error on that trailing word read raises `fault` and `dummyFault`, puts the total transfer count on `faultCount`, and suppresses `done`.
- R7: A bus error on a register read stops the sequence. No further read and no register write follows, and the base register is not written back. `fault` rises with `dummyFault`=0, and `faultCount` equals the number of transfers already completed.
- R8: With `resume`=1 at start, transfers whose index is below `doneCount` make no read and no write, yet the address still advances 4 for each of them. A `doneCount` at or above the number of set bits skips them all.
- R9: With `resume`=1 and `bufValid`=1 at start, the first register that is not skipped takes `bufData` without a bus read. Later registers read memory as usual.
- R10: `cycleCount` restarts from 0 at each start and grows by 4 for every register written from memory or from the buffer. Skipped registers add nothing.
- R11: With a zero mask, no register read is made, the base register is written back unchanged, and `done` follows. In legacy mode the trailing word read is still made at the base address.
- R12: Out of reset, and again once a load has ended, `busy`, `busReq`, `rfWe` and `done` are low. `done` is high for exactly one cycle at the end of a load that completed without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a load when the block is idle |
| legacyMode | input | 1 | 1 = make the trailing word read |
| regMask | input | 16 | Register-select mask |
| baseAddr | input | 32 | Starting address |
| baseIdx | input | 3 | Address register that holds the base |
| resume | input | 1 | Restart of an interrupted load |
| doneCount | input | 5 | Transfers already completed (restart) |
| bufValid | input | 1 | Restart with one word already fetched |
| bufData | input | 32 | That fetched word |
| busReq | output | 1 | Read request |
| busAddr | output | 32 | Read address |
| busSize | output | 1 | 0 = longword, 1 = word |
| busAck | input | 1 | Read completed, data valid |
| busErr | input | 1 | Read ended with a bus error |
| busRdata | input | 32 | Read data |
| rfWe | output | 1 | Register-file write enable |
| rfSel | output | 1 | 0 = data group, 1 = address group |
| rfIdx | output | 3 | Register index within the group |
| rfData | output | 32 | Register write data |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Last load ended in a bus error |
| dummyFault | output | 1 | That error was on the trailing word read |
| faultCount | output | 5 | Completed transfer count at the error |
| cycleCount | output | 7 | Accumulated transfer cost |

## Verification
The bench builds the block with its default parameters: eight registers per group, 32-bit address and data, and a cost of 4 per transfer. With these settings the full 16-bit mask can be used, so both groups, the highest register of each group, and the data-to-address boundary are all exercised. The restart count is wide enough to cover both a partial skip and a skip of every selected register. A bench memory returns an address-derived word, and an error can be injected at any single address. This puts a fault on a middle register read and on the trailing word read within reach, next to full, sparse and empty masks in both modes.

// File: rtl/reglist_pkg.sv
package reglist_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STEP,
    ST_READ,
    ST_DUMMY,
    ST_FIN
  } seqState_e;

  typedef enum logic [1:0] {
    WR_BUS,
    WR_BUF,
    WR_BASE
  } wrSrc_e;

  typedef struct packed {
    logic   load;
    logic   consume;
    logic   addCost;
    logic   useBuf;
    logic   setFault;
    logic   setDummy;
    wrSrc_e wrSel;
  } strobe_t;

endpackage

// File: rtl/reglist_ctrl.sv
module reglist_ctrl
  import reglist_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    maskEmpty,
  input  logic    isSkip,
  input  logic    bufPend,
  input  logic    legacyQ,
  input  logic    busAck,
  input  logic    busErr,
  output strobe_t strb,
  output logic    busReq,
  output logic    busSize,
  output logic    rfWe,
  output logic    busy,
  output logic    done
);

  seqState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    strb.wrSel = WR_BUS;
    busReq    = 1'b0;
    busSize   = 1'b0;
    rfWe      = 1'b0;
    done      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strb.load = 1'b1;
          nextState = ST_STEP;
        end
      end
      ST_STEP: begin
        if (maskEmpty) begin
          rfWe       = 1'b1;
          strb.wrSel = WR_BASE;
          nextState  = legacyQ ? ST_DUMMY : ST_FIN;
        end else if (isSkip) begin
          strb.consume = 1'b1;
        end else if (bufPend) begin
          rfWe         = 1'b1;
          strb.wrSel   = WR_BUF;
          strb.consume = 1'b1;
          strb.addCost = 1'b1;
          strb.useBuf  = 1'b1;
        end else begin
          nextState = ST_READ;
        end
      end
      ST_READ: begin
        busReq = 1'b1;
        if (busErr) begin
          strb.setFault = 1'b1;
          nextState     = ST_IDLE;
        end else if (busAck) begin
          rfWe         = 1'b1;
          strb.wrSel   = WR_BUS;
          strb.consume = 1'b1;
          strb.addCost = 1'b1;
          nextState    = ST_STEP;
        end
      end
      ST_DUMMY: begin
        busReq  = 1'b1;
        busSize = 1'b1;
        if (busErr) begin
          strb.setFault = 1'b1;
          strb.setDummy = 1'b1;
          nextState     = ST_IDLE;
        end else if (busAck) begin
          nextState = ST_FIN;
        end
      end
      ST_FIN: begin
        done      = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/reglist_dp.sv
module reglist_dp
  import reglist_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int GRP_REGS  = 8,
  parameter int XFER_COST = 4,
  localparam int MASK_W   = 2 * GRP_REGS,
  localparam int IDX_W    = $clog2(GRP_REGS),
  localparam int POS_W    = $clog2(MASK_W),
  localparam int CNT_W    = $clog2(MASK_W + 1),
  localparam int CYC_W    = $clog2(MASK_W * XFER_COST + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              legacyMode,
  input  logic [MASK_W-1:0] regMask,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [IDX_W-1:0]  baseIdx,
  input  logic              resume,
  input  logic [CNT_W-1:0]  doneCount,
  input  logic              bufValid,
  input  logic [DATA_W-1:0] bufData,
  input  logic [DATA_W-1:0] busRdata,
  output logic              maskEmpty,
  output logic              isSkip,
  output logic              bufPend,
  output logic              legacyR,
  output logic [ADDR_W-1:0] busAddr,
  output logic              rfSel,
  output logic [IDX_W-1:0]  rfIdx,
  output logic [DATA_W-1:0] rfData,
  output logic              fault,
  output logic              dummyFault,
  output logic [CNT_W-1:0]  faultCount,
  output logic [CYC_W-1:0]  cycleCount
);

  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(DATA_W / 8);

  logic [MASK_W-1:0] maskR;
  logic [ADDR_W-1:0] addrR;
  logic [CNT_W-1:0]  xferIdx;
  logic [CNT_W-1:0]  skipR;
  logic [IDX_W-1:0]  baseIdxR;
  logic [DATA_W-1:0] bufR;
  logic [CYC_W-1:0]  costR;
  logic [POS_W-1:0]  lowPos;

  // lowest selected bit: data group occupies the low half, so a single
  // lowest-first scan yields data-before-address order
  always_comb begin
    lowPos = '0;
    for (int i = MASK_W - 1; i >= 0; i--) begin
      if (maskR[i]) lowPos = POS_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskR      <= '0;
      addrR      <= '0;
      xferIdx    <= '0;
      skipR      <= '0;
      baseIdxR   <= '0;
      bufR       <= '0;
      bufPend    <= 1'b0;
      legacyR    <= 1'b0;
      costR      <= '0;
      fault      <= 1'b0;
      dummyFault <= 1'b0;
      faultCount <= '0;
    end else if (strb.load) begin
      maskR      <= regMask;
      addrR      <= baseAddr;
      xferIdx    <= '0;
      skipR      <= resume ? doneCount : '0;
      baseIdxR   <= baseIdx;
      bufR       <= bufData;
      bufPend    <= resume & bufValid;
      legacyR    <= legacyMode;
      costR      <= '0;
      fault      <= 1'b0;
      dummyFault <= 1'b0;
      faultCount <= '0;
    end else begin
      if (strb.consume) begin
        maskR   <= maskR & (maskR - MASK_W'(1));
        addrR   <= addrR + STRIDE;
        xferIdx <= xferIdx + CNT_W'(1);
      end
      if (strb.addCost) costR   <= costR + CYC_W'(XFER_COST);
      if (strb.useBuf)  bufPend <= 1'b0;
      if (strb.setFault) begin
        fault      <= 1'b1;
        dummyFault <= strb.setDummy;
        faultCount <= xferIdx;
      end
    end
  end

  assign maskEmpty  = (maskR == '0);
  assign isSkip     = (xferIdx < skipR);
  assign busAddr    = addrR;
  assign cycleCount = costR;

  always_comb begin
    rfSel  = 1'b0;
    rfIdx  = '0;
    rfData = busRdata;
    unique case (strb.wrSel)
      WR_BASE: begin
        rfSel  = 1'b1;
        rfIdx  = baseIdxR;
        rfData = DATA_W'(addrR);
      end
      WR_BUF: begin
        rfSel  = (int'(lowPos) >= GRP_REGS);
        rfIdx  = lowPos[IDX_W-1:0];
        rfData = bufR;
      end
      default: begin
        rfSel  = (int'(lowPos) >= GRP_REGS);
        rfIdx  = lowPos[IDX_W-1:0];
        rfData = busRdata;
      end
    endcase
  end

endmodule

// File: rtl/reglist_loader.sv
module reglist_loader
  import reglist_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int GRP_REGS  = 8,
  parameter int XFER_COST = 4,
  localparam int MASK_W   = 2 * GRP_REGS,
  localparam int IDX_W    = $clog2(GRP_REGS),
  localparam int CNT_W    = $clog2(MASK_W + 1),
  localparam int CYC_W    = $clog2(MASK_W * XFER_COST + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              legacyMode,
  input  logic [MASK_W-1:0] regMask,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [IDX_W-1:0]  baseIdx,
  input  logic              resume,
  input  logic [CNT_W-1:0]  doneCount,
  input  logic              bufValid,
  input  logic [DATA_W-1:0] bufData,
  output logic              busReq,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busSize,
  input  logic              busAck,
  input  logic              busErr,
  input  logic [DATA_W-1:0] busRdata,
  output logic              rfWe,
  output logic              rfSel,
  output logic [IDX_W-1:0]  rfIdx,
  output logic [DATA_W-1:0] rfData,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic              dummyFault,
  output logic [CNT_W-1:0]  faultCount,
  output logic [CYC_W-1:0]  cycleCount
);

  strobe_t strb;
  logic    maskEmpty;
  logic    isSkip;
  logic    bufPend;
  logic    legacyQ;

  reglist_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .maskEmpty (maskEmpty),
    .isSkip    (isSkip),
    .bufPend   (bufPend),
    .legacyQ   (legacyQ),
    .busAck    (busAck),
    .busErr    (busErr),
    .strb      (strb),
    .busReq    (busReq),
    .busSize   (busSize),
    .rfWe      (rfWe),
    .busy      (busy),
    .done      (done)
  );

  reglist_dp #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .GRP_REGS  (GRP_REGS),
    .XFER_COST (XFER_COST)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .legacyMode (legacyMode),
    .regMask    (regMask),
    .baseAddr   (baseAddr),
    .baseIdx    (baseIdx),
    .resume     (resume),
    .doneCount  (doneCount),
    .bufValid   (bufValid),
    .bufData    (bufData),
    .busRdata   (busRdata),
    .maskEmpty  (maskEmpty),
    .isSkip     (isSkip),
    .bufPend    (bufPend),
    .legacyR    (legacyQ),
    .busAddr    (busAddr),
    .rfSel      (rfSel),
    .rfIdx      (rfIdx),
    .rfData     (rfData),
    .fault      (fault),
    .dummyFault (dummyFault),
    .faultCount (faultCount),
    .cycleCount (cycleCount)
  );

endmodule

// File: rtl/reglist_loader_chk.sv
module reglist_loader_chk #(
  parameter int ADDR_W = 32,
  parameter int CYC_W  = 7
)(
  input logic              clk,
  input logic              rstN,
  input logic              busReq,
  input logic              busAck,
  input logic              busErr,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busSize,
  input logic              rfWe,
  input logic              busy,
  input logic              done,
  input logic              fault,
  input logic              legacyQ,
  input logic [CYC_W-1:0]  cycleCount
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck && !busErr) |=> (busReq && $stable(busAddr))); // R3

  AST_WORD_READ_LEGACY: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busSize) |-> legacyQ); // R5

  AST_DONE_NOT_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !fault); // R6

  AST_QUIET_AFTER_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (!rfWe && !busReq && !busy)); // R7

  AST_COST_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busy) && busy) |->
      (cycleCount == $past(cycleCount) || cycleCount == $past(cycleCount) + CYC_W'(4))); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R12

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!busReq && !rfWe && !done)); // R12

endmodule

bind reglist_loader reglist_loader_chk #(
  .ADDR_W (ADDR_W),
  .CYC_W  (CYC_W)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .busReq     (busReq),
  .busAck     (busAck),
  .busErr     (busErr),
  .busAddr    (busAddr),
  .busSize    (busSize),
  .rfWe       (rfWe),
  .busy       (busy),
  .done       (done),
  .fault      (fault),
  .legacyQ    (uDp.legacyR),
  .cycleCount (cycleCount)
);

// File: tb/sim_reglist_loader.sv
`timescale 1ns/1ps
module sim_reglist_loader;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        legacyMode = 1'b0;
  logic [15:0] regMask = '0;
  logic [31:0] baseAddr = '0;
  logic [2:0]  baseIdx = '0;
  logic        resume = 1'b0;
  logic [4:0]  doneCount = '0;
  logic        bufValid = 1'b0;
  logic [31:0] bufData = '0;
  logic        busReq, busSize, busAck, busErr;
  logic [31:0] busAddr, busRdata;
  logic        rfWe, rfSel;
  logic [2:0]  rfIdx;
  logic [31:0] rfData;
  logic        busy, done, fault, dummyFault;
  logic [4:0]  faultCount;
  logic [6:0]  cycleCount;

  logic        errEn = 1'b0;
  logic [31:0] errAddr = '0;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  reglist_loader u0 (
    .clk(clk), .rstN(rstN), .start(start), .legacyMode(legacyMode),
    .regMask(regMask), .baseAddr(baseAddr), .baseIdx(baseIdx),
    .resume(resume), .doneCount(doneCount), .bufValid(bufValid),
    .bufData(bufData), .busReq(busReq), .busAddr(busAddr),
    .busSize(busSize), .busAck(busAck), .busErr(busErr),
    .busRdata(busRdata), .rfWe(rfWe), .rfSel(rfSel), .rfIdx(rfIdx),
    .rfData(rfData), .busy(busy), .done(done), .fault(fault),
    .dummyFault(dummyFault), .faultCount(faultCount),
    .cycleCount(cycleCount)
  );

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  // zero-wait memory with one injectable error address
  assign busErr   = busReq && errEn && (busAddr == errAddr);
  assign busAck   = busReq && !busErr;
  assign busRdata = memWord(busAddr);

  // observed traffic
  logic [35:0] wrLog [0:39];
  logic [32:0] rdLog [0:39];
  int wrN = 0;
  int rdN = 0;
  always @(posedge clk) begin
    if (rfWe && wrN < 40) begin
      wrLog[wrN] <= {rfSel, rfIdx, rfData};
      wrN <= wrN + 1;
    end
    if (busReq && (busAck || busErr) && rdN < 40) begin
      rdLog[rdN] <= {busSize, busAddr};
      rdN <= rdN + 1;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      testsFailed++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("  [TB] %0d tests run, %0d failed", testsRun + 1, testsFailed);
      $finish;
    end
  end

  // runs one load and compares against an independent model
  task automatic runLoad(input string name, input logic [15:0] m, input logic [31:0] b,
                         input logic [2:0] bi, input logic leg, input logic res,
                         input logic [4:0] dc, input logic bv, input logic [31:0] bd,
                         input logic ee, input logic [31:0] ea);
    logic [35:0] eW [0:39];
    logic [32:0] eR [0:39];
    int ew = 0, er = 0, idx = 0, cost = 0, fcnt = 0;
    logic [31:0] a = b;
    logic bp = res & bv;
    logic eFault = 0, eDummy = 0, doneSeen = 0;
    int skip = res ? int'(dc) : 0;
    for (int i = 0; i < 16; i++) begin
      if (m[i] && !eFault) begin
        if (idx < skip) begin
          a += 4; idx++;
        end else if (bp) begin
          eW[ew] = {(i >= 8), 3'(i % 8), bd}; ew++;
          bp = 0; cost += 4; a += 4; idx++;
        end else begin
          eR[er] = {1'b0, a}; er++;
          if (ee && a == ea) begin
            eFault = 1; fcnt = idx;
          end else begin
            eW[ew] = {(i >= 8), 3'(i % 8), memWord(a)}; ew++;
            cost += 4; a += 4; idx++;
          end
        end
      end
    end
    if (!eFault) begin
      eW[ew] = {1'b1, bi, a}; ew++;
      if (leg) begin
        eR[er] = {1'b1, a}; er++;
        if (ee && a == ea) begin
          eFault = 1; eDummy = 1; fcnt = idx;
        end
      end
    end

    @(negedge clk);
    wrN = 0; rdN = 0;
    regMask = m; baseAddr = b; baseIdx = bi; legacyMode = leg; resume = res;
    doneCount = dc; bufValid = bv; bufData = bd; errEn = ee; errAddr = ea;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 200; t++) begin
      if (done) doneSeen = 1;
      if (done || fault) break;
      @(negedge clk);
    end
    @(negedge clk);
    check({name, " R12 done pulse"}, {63'd0, doneSeen}, {63'd0, !eFault});
    check({name, " R12 done one cycle"}, {62'd0, done, busy}, 64'd0);
    check({name, " R1 R2 write count"}, 64'(wrN), 64'(ew));
    for (int k = 0; k < ew && k < wrN; k++)
      check($sformatf("%s R2 R4 write %0d", name, k), 64'(wrLog[k]), 64'(eW[k]));
    check({name, " R3 R5 read count"}, 64'(rdN), 64'(er));
    for (int k = 0; k < er && k < rdN; k++)
      check($sformatf("%s R3 R5 read %0d", name, k), 64'(rdLog[k]), 64'(eR[k]));
    check({name, " R6 R7 fault flags"}, {62'd0, fault, dummyFault}, {62'd0, eFault, eDummy});
    if (eFault) check({name, " R7 faultCount"}, 64'(faultCount), 64'(fcnt));
    check({name, " R10 cycleCount"}, 64'(cycleCount), 64'(cost));
    errEn = 1'b0; resume = 1'b0; bufValid = 1'b0;
  endtask

  task automatic testReset();
    check("R12 reset idle", {59'd0, busy, busReq, rfWe, done, fault}, 64'd0);
  endtask

  task automatic testMixedNew();
    // D0 D7 A0 A1 A7, no trailing read
    runLoad("mixed R1", 16'h8381, 32'h0000_1000, 3'd3, 1'b0, 1'b0, 5'd0, 1'b0, 32'h0, 1'b0, 32'h0);
  endtask

  task automatic testFullLegacy();
    runLoad("full R5", 16'hFFFF, 32'h0000_2000, 3'd7, 1'b1, 1'b0, 5'd0, 1'b0, 32'h0, 1'b0, 32'h0);
  endtask

  task automatic testZeroMask();
    runLoad("zero new R11", 16'h0000, 32'h0000_5000, 3'd2, 1'b0, 1'b0, 5'd0, 1'b0, 32'h0, 1'b0, 32'h0);
    runLoad("zero legacy R11", 16'h0000, 32'h0000_5100, 3'd5, 1'b1, 1'b0, 5'd0, 1'b0, 32'h0, 1'b0, 32'h0);
  endtask

  task automatic testReadError();
    runLoad("rderr R7", 16'h0F0F, 32'h0000_3000, 3'd1, 1'b1, 1'b0, 5'd0, 1'b0, 32'h0, 1'b1, 32'h0000_3008);
  endtask

  task automatic testRestartSkip();
    runLoad("skip R8", 16'h0F0F, 32'h0000_3000, 3'd1, 1'b0, 1'b1, 5'd2, 1'b0, 32'h0, 1'b0, 32'h0);
    runLoad("skipall R8", 16'h0003, 32'h0000_6000, 3'd4, 1'b0, 1'b1, 5'd5, 1'b0, 32'h0, 1'b0, 32'h0);
  endtask

  task automatic testRestartBuffer();
    runLoad("buffer R9", 16'h0F0F, 32'h0000_3000, 3'd1, 1'b1, 1'b1, 5'd2, 1'b1, 32'hDEAD_BEEF, 1'b0, 32'h0);
  endtask

  task automatic testDummyError();
    runLoad("dummyerr R6", 16'h0003, 32'h0000_4000, 3'd6, 1'b1, 1'b0, 5'd0, 1'b0, 32'h0, 1'b1, 32'h0000_4008);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMixedNew();
    testFullLegacy();
    testZeroMask();
    testReadError();
    testRestartSkip();
    testRestartBuffer();
    testDummyError();
    testMixedNew();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule